// File: doc/BRIEF.md
# Branch condition and target unit

This block resolves conditional branches for a 32-bit RISC-V style core. It takes the instruction word, the address of that instruction and the two source operand values. From these it decides whether the word is a conditional branch, whether the branch is taken, and where it goes. The block finds the six compare kinds from the 3-bit condition field. It gathers the branch displacement from its split positions in the word, sign-extends it and adds it to the instruction's own address.

The compare and target logic is combinational. A parameter selects whether the three results leave through a register stage or straight from the logic. With the default setting, a result appears one clock after its inputs, and a synchronous active-high reset clears the registered results. The block does not read the register file, update the program counter, or flush a pipeline. The surrounding core owns those tasks.

Top module: `brcond_unit`

## Requirements
- R1: `is_branch_o` is 1 only when bits [6:0] of the word equal 1100011 and bits [14:12] hold one of 000, 001, 100, 101, 110, 111; otherwise it is 0.
- R2: `taken_o` is 0 whenever `is_branch_o` is 0: for any other major opcode and for condition codes 010 and 011 under the branch opcode.
- R3: Condition 000 is taken when the two operands are bit-for-bit equal, and condition 001 is taken when they differ.
- R4: Condition 100 is taken when operand one is less than operand two as two's complement values, and condition 101 when it is greater or equal; 0x80000000 is the most negative value, and equal operands take 101.
- R5: Condition 110 is taken when operand one is less than operand two as unsigned values, and condition 111 when it is greater or equal; equal operands take 111.
- R6: The displacement is {word[31], word[7], word[30:25], word[11:8], 0}, a 13-bit two's complement byte count (range -4096 to +4094, always even). The target is the instruction address plus the sign-extended displacement, modulo 2^32.
- R7: The target is formed from the word's displacement bits for every input, whether or not the word is a branch and whether or not the branch is taken.
- R8: With the default registered output, all three results reflect the inputs present at the previous rising clock edge; while reset is high at an edge, all three outputs become 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| inst_i | input | 32 | Instruction word under evaluation |
| pc_i | input | 32 | Address of that instruction |
| rs1_val_i | input | 32 | First source operand value |
| rs2_val_i | input | 32 | Second source operand value |
| is_branch_o | output | 1 | Word is a conditional branch with a defined condition |
| taken_o | output | 1 | Branch condition holds |
| target_o | output | 32 | Instruction address plus displacement |

## Verification
The compare decision and the target sum are produced in the same cycle from the same word. A mistake in field extraction can therefore corrupt one result while the other still looks correct. The bench provokes both results together with vectors that put a signed-versus-unsigned disagreement (0x80000000 against 1) in a word whose displacement is at an extreme or wraps the address past zero or past 0xFFFFFFFC. It encodes each word from an integer displacement, so the check runs in the opposite direction to the decoder, and it judges the taken flag, the branch flag and the target of one registered result as a single item.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

    localparam int unsigned INST_W   = 32;
    localparam int unsigned DISP_W   = 13;
    localparam logic [6:0]  OPC_BRCH = 7'b1100011;

    typedef enum logic [2:0] {
        CMP_EQ   = 3'b000,
        CMP_NE   = 3'b001,
        CMP_RSV2 = 3'b010,
        CMP_RSV3 = 3'b011,
        CMP_LT   = 3'b100,
        CMP_GE   = 3'b101,
        CMP_LTU  = 3'b110,
        CMP_GEU  = 3'b111
    } cmp_kind_e;

    typedef struct packed {
        logic      valid;
        cmp_kind_e kind;
    } br_ctl_t;

    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } cmp_flags_t;

    function automatic logic kind_defined(input cmp_kind_e k);
        return (k != CMP_RSV2) && (k != CMP_RSV3);
    endfunction

    function automatic logic [DISP_W-1:0] gather_disp(input logic [INST_W-1:0] w);
        return {w[31], w[7], w[30:25], w[11:8], 1'b0};
    endfunction

    function automatic logic pick_outcome(input cmp_kind_e k, input cmp_flags_t f);
        logic r;
        case (k)
            CMP_EQ:  r = f.eq;
            CMP_NE:  r = !f.eq;
            CMP_LT:  r = f.lt_s;
            CMP_GE:  r = !f.lt_s;
            CMP_LTU: r = f.lt_u;
            CMP_GEU: r = !f.lt_u;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/brcond_decode.sv
module brcond_decode
    import brcond_pkg::*;
(
    input  logic [INST_W-1:0] inst,
    output br_ctl_t           ctl,
    output logic [DISP_W-1:0] disp_raw
);
    cmp_kind_e kind;
    logic      opc_hit;
    logic      unused_regfields;

    assign unused_regfields = ^inst[24:15];

    assign opc_hit   = (inst[6:0] == OPC_BRCH);
    assign kind      = cmp_kind_e'(inst[14:12]);
    assign ctl.kind  = kind;
    assign ctl.valid = opc_hit && kind_defined(kind);
    assign disp_raw  = gather_disp(inst);

endmodule

// File: rtl/brcond_compare.sv
module brcond_compare
    import brcond_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  br_ctl_t         ctl,
    output logic            taken
);
    localparam int unsigned MSB = XLEN - 1;

    cmp_flags_t flags;
    logic       sign_differs;

    assign flags.eq     = (opa == opb);
    assign flags.lt_u   = (opa < opb);
    assign sign_differs = opa[MSB] ^ opb[MSB];
    // Opposite signs: the negative operand is the smaller one.
    assign flags.lt_s   = sign_differs ? opa[MSB] : flags.lt_u;

    assign taken = ctl.valid && pick_outcome(ctl.kind, flags);

endmodule

// File: rtl/brcond_target.sv
module brcond_target
    import brcond_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [DISP_W-1:0] disp_raw,
    output logic [XLEN-1:0]   target
);
    localparam int unsigned EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{disp_raw[DISP_W-1]}}, disp_raw};
        end else begin : g_trunc
            assign disp_ext = disp_raw[XLEN-1:0];
        end
    endgenerate

    assign target = pc + disp_ext;

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
    import brcond_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [INST_W-1:0]   inst_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [XLEN-1:0]     rs1_val_i,
    input  logic [XLEN-1:0]     rs2_val_i,
    output logic                is_branch_o,
    output logic                taken_o,
    output logic [XLEN-1:0]     target_o
);
    typedef struct packed {
        logic            is_br;
        logic            taken;
        logic [XLEN-1:0] target;
    } res_t;

    br_ctl_t           ctl;
    logic [DISP_W-1:0] disp_raw;
    res_t              res_d;
    res_t              res_q;

    brcond_decode u_dec (
        .inst     (inst_i),
        .ctl      (ctl),
        .disp_raw (disp_raw)
    );

    brcond_compare #(.XLEN(XLEN)) u_cmp (
        .opa   (rs1_val_i),
        .opb   (rs2_val_i),
        .ctl   (ctl),
        .taken (res_d.taken)
    );

    brcond_target #(.XLEN(XLEN)) u_tgt (
        .pc       (pc_i),
        .disp_raw (disp_raw),
        .target   (res_d.target)
    );

    assign res_d.is_br = ctl.valid;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst;
            assign res_q = res_d;
        end
    endgenerate

    assign is_branch_o = res_q.is_br;
    assign taken_o     = res_q.taken;
    assign target_o    = res_q.target;

endmodule

// File: rtl/brcond_checks.sv
module brcond_checks
    import brcond_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [INST_W-1:0] inst_i,
    input logic [XLEN-1:0]   pc_i,
    input logic [XLEN-1:0]   rs1_val_i,
    input logic [XLEN-1:0]   rs2_val_i,
    input logic              is_branch_o,
    input logic              taken_o,
    input logic [XLEN-1:0]   target_o
);
    logic unused_chk;
    assign unused_chk = ^inst_i[24:15];

    // R2: a taken result always comes with a branch indication
    p_taken_needs_branch_r2: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> is_branch_o);

    generate
        if (REG_OUT) begin : g_reg_chk
            // R1: a foreign opcode never yields a branch one cycle later
            p_foreign_opcode_r1: assert property (@(posedge clk) disable iff (rst)
                (inst_i[6:0] != OPC_BRCH) |=> (!is_branch_o && !taken_o));

            // R3: equality condition
            p_eq_cond_r3: assert property (@(posedge clk) disable iff (rst)
                (inst_i[6:0] == OPC_BRCH && inst_i[14:12] == 3'b000)
                |=> (taken_o == ($past(rs1_val_i) == $past(rs2_val_i))));

            // R3: inequality condition
            p_ne_cond_r3: assert property (@(posedge clk) disable iff (rst)
                (inst_i[6:0] == OPC_BRCH && inst_i[14:12] == 3'b001)
                |=> (taken_o != ($past(rs1_val_i) == $past(rs2_val_i))));

            // R4: signed greater-or-equal is taken on equal operands
            p_ge_equal_r4: assert property (@(posedge clk) disable iff (rst)
                (inst_i[6:0] == OPC_BRCH && inst_i[14:12] == 3'b101 && rs1_val_i == rs2_val_i)
                |=> taken_o);

            // R5: unsigned less-than condition
            p_ltu_cond_r5: assert property (@(posedge clk) disable iff (rst)
                (inst_i[6:0] == OPC_BRCH && inst_i[14:12] == 3'b110)
                |=> (taken_o == ($past(rs1_val_i) < $past(rs2_val_i))));

            // R6, R7: zero displacement targets the instruction itself
            p_zero_disp_r6: assert property (@(posedge clk) disable iff (rst)
                (inst_i[31:25] == 7'd0 && inst_i[11:7] == 5'd0)
                |=> (target_o == $past(pc_i)));

            // R8: reset clears every output
            p_reset_clear_r8: assert property (@(posedge clk)
                rst |=> (!is_branch_o && !taken_o && target_o == '0));
        end
    endgenerate

endmodule

bind brcond_unit brcond_checks #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .inst_i      (inst_i),
    .pc_i        (pc_i),
    .rs1_val_i   (rs1_val_i),
    .rs2_val_i   (rs2_val_i),
    .is_branch_o (is_branch_o),
    .taken_o     (taken_o),
    .target_o    (target_o)
);

// File: tb/sim_brcond_unit.sv
module sim_brcond_unit;

    localparam logic [6:0] BR  = 7'b1100011;
    localparam logic [6:0] ALU = 7'b0110011;

    typedef struct {
        string       tag;
        logic        isb;
        logic        tk;
        logic [31:0] tgt;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] inst = '0;
    logic [31:0] pc = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        is_branch_o;
    logic        taken_o;
    logic [31:0] target_o;

    int    n_chk = 0;
    int    n_bad = 0;
    item_t sbq[$];

    always #5 clk = ~clk;

    brcond_unit u0 (
        .clk         (clk),
        .rst         (rst),
        .inst_i      (inst),
        .pc_i        (pc),
        .rs1_val_i   (a),
        .rs2_val_i   (b),
        .is_branch_o (is_branch_o),
        .taken_o     (taken_o),
        .target_o    (target_o)
    );

    // Encode a displacement (even, -4096..4094) into the split fields
    function automatic logic [31:0] enc(input logic [6:0] opc, input logic [2:0] f3, input int disp);
        logic [12:0] o;
        o = disp[12:0];
        return {o[12], o[10:5], 5'd7, 5'd3, f3, o[4:1], o[11], opc};
    endfunction

    function automatic item_t model(input logic [6:0] opc, input logic [2:0] f3,
                                    input logic [31:0] pcv, input logic [31:0] x,
                                    input logic [31:0] y, input int disp);
        item_t it;
        logic  c;
        it.isb = (opc == BR) && (f3 != 3'b010) && (f3 != 3'b011);
        case (f3)
            3'b000:  c = (x == y);
            3'b001:  c = (x != y);
            3'b100:  c = ($signed(x) < $signed(y));
            3'b101:  c = ($signed(x) >= $signed(y));
            3'b110:  c = (x < y);
            3'b111:  c = (x >= y);
            default: c = 1'b0;
        endcase
        it.tk  = it.isb && c;
        it.tgt = pcv + 32'(disp);
        it.tag = "";
        return it;
    endfunction

    task automatic apply(input string tag, input logic [6:0] opc, input logic [2:0] f3,
                         input logic [31:0] pcv, input logic [31:0] x,
                         input logic [31:0] y, input int disp);
        item_t it;
        @(negedge clk);
        inst = enc(opc, f3, disp);
        pc   = pcv;
        a    = x;
        b    = y;
        it     = model(opc, f3, pcv, x, y, disp);
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: one result per rising edge, sampled 1 ns after it (R8 latency)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin : pop_blk
                item_t it;
                it = sbq.pop_front();
                n_chk++;
                if (is_branch_o !== it.isb || taken_o !== it.tk || target_o !== it.tgt) begin
                    n_bad++;
                    $display("FAIL %s: got br=%0b tk=%0b tgt=%h, expected br=%0b tk=%0b tgt=%h",
                             it.tag, is_branch_o, taken_o, target_o, it.isb, it.tk, it.tgt);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got running, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic check_zero(input string tag);
        n_chk++;
        if (is_branch_o !== 1'b0 || taken_o !== 1'b0 || target_o !== 32'h0) begin
            n_bad++;
            $display("FAIL %s: got br=%0b tk=%0b tgt=%h, expected br=0 tk=0 tgt=00000000",
                     tag, is_branch_o, taken_o, target_o);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_zero("R8 reset state");
        @(negedge clk);
        rst = 1'b0;

        // R3 equality / inequality
        apply("R3 beq equal",     BR, 3'b000, 32'h0000_1000, 32'h1234_5678, 32'h1234_5678, 16);
        apply("R3 beq differ",    BR, 3'b000, 32'h0000_1000, 32'h1234_5678, 32'h1234_5679, 16);
        apply("R3 bne equal",     BR, 3'b001, 32'h0000_2000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, -16);
        apply("R3 bne differ",    BR, 3'b001, 32'h0000_2000, 32'h0000_0000, 32'h8000_0000, -16);
        // R4 signed
        apply("R4 blt min vs 1",  BR, 3'b100, 32'h0000_0040, 32'h8000_0000, 32'h0000_0001, 8);
        apply("R4 blt 1 vs min",  BR, 3'b100, 32'h0000_0040, 32'h0000_0001, 32'h8000_0000, 8);
        apply("R4 blt -5 vs -3",  BR, 3'b100, 32'h0000_0040, 32'hFFFF_FFFB, 32'hFFFF_FFFD, 8);
        apply("R4 bge equal",     BR, 3'b101, 32'h0000_0080, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 4);
        apply("R4 bge -1 vs 0",   BR, 3'b101, 32'h0000_0080, 32'hFFFF_FFFF, 32'h0000_0000, 4);
        // R5 unsigned
        apply("R5 bltu min vs 1", BR, 3'b110, 32'h0000_0100, 32'h8000_0000, 32'h0000_0001, 2);
        apply("R5 bltu 1 vs max", BR, 3'b110, 32'h0000_0100, 32'h0000_0001, 32'hFFFF_FFFF, 2);
        apply("R5 bgeu equal",    BR, 3'b111, 32'h0000_0100, 32'h0000_0005, 32'h0000_0005, 2);
        apply("R5 bgeu 0 vs max", BR, 3'b111, 32'h0000_0100, 32'h0000_0000, 32'hFFFF_FFFF, 2);
        // R1, R2, R7: non-branches, target still formed
        apply("R2 foreign opcode equal regs", ALU, 3'b000, 32'h0000_3000, 32'h5, 32'h5, 100);
        apply("R1 code 010 undefined",        BR,  3'b010, 32'h0000_3000, 32'h5, 32'h9, 100);
        apply("R1 code 011 undefined",        BR,  3'b011, 32'h0000_3000, 32'h9, 32'h5, -100);
        apply("R7 not-taken target",          BR,  3'b000, 32'h0000_4000, 32'h1, 32'h2, 2730);
        // R6 displacement extremes and wrap, combined with sign disagreement
        apply("R6 max forward",   BR, 3'b100, 32'h0001_0000, 32'h8000_0000, 32'h1, 4094);
        apply("R6 max backward",  BR, 3'b110, 32'h0001_0000, 32'h8000_0000, 32'h1, -4096);
        apply("R6 wrap below 0",  BR, 3'b101, 32'h0000_0000, 32'h8000_0000, 32'h1, -8);
        apply("R6 wrap above top",BR, 3'b111, 32'hFFFF_FFFC, 32'h8000_0000, 32'h1, 8);
        apply("R6 minus two",     BR, 3'b001, 32'h0000_0010, 32'h3, 32'h4, -2);

        // Mixed vectors across all codes and both opcodes
        for (int i = 0; i < 300; i++) begin
            logic [2:0]  f3;
            logic [31:0] x;
            logic [31:0] y;
            int          d;
            f3 = 3'($urandom());
            x  = $urandom();
            y  = (i % 4 == 0) ? x : $urandom();
            if (i % 7 == 0) y = ~x;
            d  = int'($urandom() % 4096) * 2 - 4096;
            apply("R3 R4 R5 R6 mixed", (i % 9 == 0) ? ALU : BR, f3, $urandom(), x, y, d);
        end

        // R8: a taken result, then reset clears it
        apply("R8 before reset", BR, 3'b000, 32'h0000_5000, 32'h7, 32'h7, 64);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check_zero("R8 reset clears outputs");
        repeat (2) @(posedge clk);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule